// File: doc/BRIEF.md
# Asynchronous Line Distortion Checker

This block watches an asynchronous serial line with a sample clock running at `OSR` (default 32) times the bit rate. When the line falls while idle it treats the fall as the start of a frame. The frame is one start bit, `DATA_BITS` data bits and one stop bit. Time inside each bit is counted in units of 1/`OSR` of a bit. Every later transition on the line is compared with the nearest ideal bit boundary. If a transition lands further from that boundary than the selected tolerance, a sticky distortion flag is set.

Each bit is taken at the middle count of its period. Data bits appear on `bit_out` with a one-cycle `bit_valid` strobe. In the regenerating modes the block also drives `regen_out`, a clean copy of the frame. Its transitions fall exactly on the sample points, so all incoming jitter is removed. A low stop bit sets a sticky framing flag. Both flags feed a common error output. Only reset clears the flags.

Top module: `line_distortion_checker`

## Requirements
- R1: A high-to-low change of `rx_in` while idle starts a frame. If the line is high again when the start bit is sampled (count 16), the frame is dropped: no strobe, and `regen_out` stays 1.
- R2: Each data bit is sampled at count 16 of its period, counted from the start edge. Bits are delivered in line order. The first data bit's strobe appears after the 48th clock edge following the start edge. `bit_valid` is high for exactly one cycle.
- R3: A frame is one start bit (low), `DATA_BITS` data bits and one stop bit. A stop bit sampled low sets `frame_err`.
- R4: A line transition at count p of a bit has deviation min(p, 32-p). Tolerance code c (00, 01, 10, 11) permits 6, 8, 10 or 12 counts. A deviation above the limit sets `dist_err` on the clock edge where the transition is seen. A deviation equal to the limit does not set it.
- R5: `dist_err` and `frame_err` stay set until reset, across any number of later clean frames.
- R6: `err_any` is high whenever either sticky flag is high.
- R7: `mode` 00 only checks the line: no strobe, `bit_out` does not change, and `regen_out` stays 1. Mode 01 strobes data and keeps `regen_out` at 1. Modes 10 and 11 strobe data and regenerate.
- R8: In the regenerating modes, `regen_out` changes only at sample points. It goes low at the start-bit sample, copies each data sample, and returns to 1 at the stop-bit sample. Distortion within tolerance does not move its transitions.
- R9: Reset is synchronous and active high. It leaves `bit_valid`, `bit_out`, `dist_err`, `frame_err` and `err_any` at 0, `regen_out` at 1, and the receiver idle.
- R10: A transition that lands exactly on a sample count is judged and sampled in the same cycle. The flag and the strobe rise together, and the strobe carries the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OSR` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high, already synchronised |
| mode | input | 2 | Operating mode (see R7) |
| tol_sel | input | 2 | Distortion tolerance code (see R4) |
| bit_out | output | 1 | Last recovered data bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` |
| regen_out | output | 1 | Regenerated serial line |
| dist_err | output | 1 | Sticky distortion flag |
| frame_err | output | 1 | Sticky stop-bit flag |
| err_any | output | 1 | Common error output |

## Verification
The edge judge and the bit sampler can act in the same cycle when a transition lands exactly on count 16 of a bit. The bench provokes this by delaying one data transition by 16 counts, with every tolerance below that. It then requires that `dist_err` and `bit_valid` first appear after the same clock edge, and that the strobed bit already carries the new level. The tolerance boundaries are probed on both sides of an ideal boundary, with each code placed at its limit and one count past it.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_CHECK     = 2'd0,
        OP_RECV      = 2'd1,
        OP_REGEN     = 2'd2,
        OP_REGEN_ALT = 2'd3
    } op_mode_e;

    // Timing events handed from the bit timer to the other stages
    typedef struct packed {
        line_st_e st;
        logic     smp;
        logic     edge_ev;
    } tick_t;

    // Registered results of the bit recovery stage
    typedef struct packed {
        logic bit_val;
        logic strobe;
        logic regen;
        logic frame_err;
    } rec_out_t;

    // Allowed deviation in sample counts: (6 + 2*code)/32 of a bit
    function automatic logic [7:0] tol_limit(input logic [1:0] code, input logic [7:0] osr);
        logic [15:0] p;
        p = (16'(code) * 16'd2 + 16'd6) * 16'(osr);
        return 8'(p >> 5);
    endfunction

    // Distance of a transition from the nearest ideal boundary
    function automatic logic [7:0] edge_dev(input logic [7:0] ph, input logic [7:0] osr);
        return (ph < (osr >> 1)) ? ph : (osr - ph);
    endfunction

endpackage

// File: rtl/ldc_bit_timer.sv
module ldc_bit_timer
    import ldc_pkg::*;
#(
    parameter int OSR       = 32,
    parameter int DATA_BITS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_in,
    output tick_t                  tk,
    output logic [$clog2(OSR)-1:0] ph
);
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_BITS + 1);
    localparam logic [PH_W-1:0]  HALF     = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    logic             rx_q;
    line_st_e         st;
    logic [IDX_W-1:0] idx;
    logic             smp;

    assign smp        = (st != LN_IDLE) && (ph == HALF);
    assign tk.st      = st;
    assign tk.smp     = smp;
    assign tk.edge_ev = (st != LN_IDLE) && (rx_in != rx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= 1'b1;
            st   <= LN_IDLE;
            ph   <= '0;
            idx  <= '0;
        end else begin
            rx_q <= rx_in;
            if (st == LN_IDLE) begin
                if (rx_q && !rx_in) begin
                    st  <= LN_START;
                    ph  <= PH_W'(1);
                    idx <= '0;
                end
            end else begin
                ph <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
                if (smp) begin
                    unique case (st)
                        LN_START: st <= rx_in ? LN_IDLE : LN_DATA;
                        LN_DATA: begin
                            if (idx == IDX_LAST) st <= LN_STOP;
                            else                 idx <= idx + IDX_W'(1);
                        end
                        LN_STOP: st <= LN_IDLE;
                        default: st <= LN_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ldc_edge_judge.sv
module ldc_edge_judge
    import ldc_pkg::*;
#(
    parameter int OSR = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   edge_ev,
    input  logic [$clog2(OSR)-1:0] ph,
    input  logic [1:0]             tol_sel,
    output logic                   dist_err
);
    logic [7:0] dev;
    logic [7:0] lim;
    logic       over;

    assign dev  = edge_dev(8'(ph), 8'(OSR));
    assign lim  = tol_limit(tol_sel, 8'(OSR));
    assign over = edge_ev && (dev > lim);

    always_ff @(posedge clk) begin
        if (rst)       dist_err <= 1'b0;
        else if (over) dist_err <= 1'b1;
    end

endmodule

// File: rtl/ldc_bit_recover.sv
module ldc_bit_recover
    import ldc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  line_st_e st,
    input  logic     smp,
    input  logic     rx_in,
    input  op_mode_e mode,
    output rec_out_t ro
);
    logic deliver;
    logic regen_on;

    assign deliver  = (mode != OP_CHECK);
    assign regen_on = (mode == OP_REGEN) || (mode == OP_REGEN_ALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ro.bit_val   <= 1'b0;
            ro.strobe    <= 1'b0;
            ro.regen     <= 1'b1;
            ro.frame_err <= 1'b0;
        end else begin
            ro.strobe <= 1'b0;
            if (smp) begin
                unique case (st)
                    LN_START: begin
                        if (!rx_in) ro.regen <= !regen_on;
                    end
                    LN_DATA: begin
                        if (deliver) begin
                            ro.bit_val <= rx_in;
                            ro.strobe  <= 1'b1;
                        end
                        ro.regen <= regen_on ? rx_in : 1'b1;
                    end
                    LN_STOP: begin
                        ro.regen <= 1'b1;
                        if (!rx_in) ro.frame_err <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/line_distortion_checker.sv
module line_distortion_checker
    import ldc_pkg::*;
#(
    parameter int OSR       = 32,
    parameter int DATA_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_in,
    input  logic [1:0] mode,
    input  logic [1:0] tol_sel,
    output logic       bit_out,
    output logic       bit_valid,
    output logic       regen_out,
    output logic       dist_err,
    output logic       frame_err,
    output logic       err_any
);
    localparam int PH_W = $clog2(OSR);

    tick_t           tk;
    logic [PH_W-1:0] ph;
    rec_out_t        ro;

    ldc_bit_timer #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .tk    (tk),
        .ph    (ph)
    );

    ldc_edge_judge #(.OSR(OSR)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .edge_ev  (tk.edge_ev),
        .ph       (ph),
        .tol_sel  (tol_sel),
        .dist_err (dist_err)
    );

    ldc_bit_recover u_recover (
        .clk   (clk),
        .rst   (rst),
        .st    (tk.st),
        .smp   (tk.smp),
        .rx_in (rx_in),
        .mode  (op_mode_e'(mode)),
        .ro    (ro)
    );

    assign bit_out   = ro.bit_val;
    assign bit_valid = ro.strobe;
    assign regen_out = ro.regen;
    assign frame_err = ro.frame_err;
    assign err_any   = dist_err | ro.frame_err;

endmodule

// File: rtl/ldc_sva.sv
module ldc_sva (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       smp,
    input logic       edge_ev,
    input logic       bit_valid,
    input logic       regen_out,
    input logic       dist_err,
    input logic       frame_err
);
    // R2: a strobe lasts one cycle and follows a sample point
    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);
    p_valid_cause_r2: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(smp));

    // R3: the framing flag rises only at a sample point
    p_frame_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> $past(smp));

    // R4: the distortion flag rises only after a seen transition
    p_dist_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dist_err) |-> $past(edge_ev));

    // R5: both flags hold until reset
    p_dist_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        dist_err |=> dist_err);
    p_frame_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

    // R7: check-only mode never strobes
    p_check_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(mode) == 2'b00) |-> !bit_valid);

    // R8: the regenerated line moves only at sample points
    p_regen_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !smp |=> $stable(regen_out));
endmodule

bind line_distortion_checker ldc_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .smp       (tk.smp),
    .edge_ev   (tk.edge_ev),
    .bit_valid (bit_valid),
    .regen_out (regen_out),
    .dist_err  (dist_err),
    .frame_err (frame_err)
);

// File: tb/line_distortion_checker_test.sv
module line_distortion_checker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] mode = 2'b01;
    logic [1:0] tol_sel = 2'b00;
    logic       bit_out, bit_valid, regen_out, dist_err, frame_err, err_any;

    int n_chk = 0;
    int n_bad = 0;

    // per-frame observations
    int         r_cnt;
    logic [7:0] r_data;
    int         r_first;
    int         r_regen_bad;
    int         r_err_at;
    logic       r_valid_at_err;

    always #4 clk = ~clk;

    line_distortion_checker uut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .mode(mode), .tol_sel(tol_sel),
        .bit_out(bit_out), .bit_valid(bit_valid), .regen_out(regen_out),
        .dist_err(dist_err), .frame_err(frame_err), .err_any(err_any)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_in = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // line level at cycle n of a frame; boundary oidx shifted by oval counts
    function automatic logic line_level(int n, logic [7:0] d, int oidx, int oval, logic stop_v);
        logic v = 1'b1;
        for (int j = 0; j <= 10; j++) begin
            int   pos;
            logic b;
            pos = 32 * j + ((j == oidx) ? oval : 0);
            b = (j == 0) ? 1'b0 : (j <= 8) ? d[j-1] : (j == 9) ? stop_v : 1'b1;
            if (n >= pos) v = b;
        end
        return v;
    endfunction

    function automatic logic exp_regen(int m, logic [7:0] d, logic regen_mode);
        int j;
        if (m < 16) return 1'b1;
        j = (m - 16) / 32;
        if (j == 0) return !regen_mode;
        if (j <= 8) return regen_mode ? d[j-1] : 1'b1;
        return 1'b1;
    endfunction

    task automatic run_frame(input logic [7:0] d, input int oidx, input int oval,
                             input logic stop_v, input logic regen_mode);
        r_cnt = 0; r_data = '0; r_first = -1; r_regen_bad = 0;
        r_err_at = -1; r_valid_at_err = 1'b0;
        for (int n = 0; n < 340; n++) begin
            int m;
            @(negedge clk);
            m = n - 1;  // outputs now reflect clock edge m
            if (m >= 0) begin
                if (bit_valid) begin
                    if (r_cnt < 8) r_data[r_cnt] = bit_out;
                    if (r_first < 0) r_first = m;
                    r_cnt++;
                end
                if (regen_out != exp_regen(m, d, regen_mode)) r_regen_bad++;
                if (dist_err && r_err_at < 0) begin
                    r_err_at = m;
                    r_valid_at_err = bit_valid;
                end
            end
            rx_in = line_level(n, d, oidx, oval, stop_v);
        end
        @(negedge clk);
        rx_in = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R9", "bit_valid after reset", bit_valid, 0);
        chk("R9", "bit_out after reset", bit_out, 0);
        chk("R9", "regen_out after reset", regen_out, 1);
        chk("R9", "flags after reset", {dist_err, frame_err, err_any}, 0);
    endtask

    task automatic t_clean_recv();
        do_reset();
        mode = 2'b01; tol_sel = 2'b00;
        run_frame(8'hA5, 0, 0, 1'b1, 1'b0);
        chk("R2", "strobe count", r_cnt, 8);
        chk("R2", "recovered byte", r_data, 8'hA5);
        chk("R2", "first strobe edge", r_first, 48);
        chk("R3", "clean frame flags", {dist_err, frame_err}, 0);
        chk("R7", "receive mode regen idle", r_regen_bad, 0);
    endtask

    task automatic t_tol_window();
        for (int c = 0; c < 4; c++) begin
            int lim;
            lim = 6 + 2 * c;
            do_reset();
            mode = 2'b01; tol_sel = 2'(c);
            run_frame(8'h55, 3, lim, 1'b1, 1'b0);
            chk("R4", $sformatf("code %0d late at limit", c), dist_err, 0);
            do_reset();
            run_frame(8'h55, 3, -(lim + 1), 1'b1, 1'b0);
            chk("R4", $sformatf("code %0d early past limit", c), dist_err, 1);
            chk("R4", $sformatf("code %0d flag edge", c), r_err_at, 96 - (lim + 1));
        end
        do_reset();
        tol_sel = 2'b00;
        run_frame(8'h55, 5, 7, 1'b1, 1'b0);
        chk("R4", "code 0 late past limit", dist_err, 1);
        do_reset();
        run_frame(8'h55, 5, -6, 1'b1, 1'b0);
        chk("R4", "code 0 early at limit", dist_err, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        mode = 2'b01; tol_sel = 2'b00;
        run_frame(8'h55, 2, 9, 1'b1, 1'b0);
        run_frame(8'h0F, 0, 0, 1'b1, 1'b0);
        chk("R5", "dist_err after clean frame", dist_err, 1);
        chk("R6", "err_any from dist_err", err_any, 1);
        do_reset();
        chk("R5", "dist_err cleared by reset", dist_err, 0);
        chk("R6", "err_any cleared", err_any, 0);
    endtask

    task automatic t_check_only();
        do_reset();
        mode = 2'b00; tol_sel = 2'b00;
        run_frame(8'h55, 4, 9, 1'b1, 1'b0);
        chk("R7", "check mode strobes", r_cnt, 0);
        chk("R7", "check mode bit_out", bit_out, 0);
        chk("R7", "check mode regen", r_regen_bad, 0);
        chk("R7", "check mode still judges", dist_err, 1);
    endtask

    task automatic t_regen();
        do_reset();
        mode = 2'b10; tol_sel = 2'b00;
        run_frame(8'h3C, 4, 5, 1'b1, 1'b1);
        chk("R8", "regen mismatches", r_regen_bad, 0);
        chk("R8", "regen byte", r_data, 8'h3C);
        chk("R8", "regen no flag", dist_err, 0);
        mode = 2'b11;
        run_frame(8'hC9, 7, -6, 1'b1, 1'b1);
        chk("R8", "alt regen mismatches", r_regen_bad, 0);
    endtask

    task automatic t_false_start();
        int strobes = 0;
        int regen_low = 0;
        do_reset();
        mode = 2'b10; tol_sel = 2'b00;
        for (int n = 0; n < 70; n++) begin
            @(negedge clk);
            if (bit_valid) strobes++;
            if (!regen_out) regen_low++;
            rx_in = (n < 5) ? 1'b0 : 1'b1;
        end
        chk("R1", "false start strobes", strobes, 0);
        chk("R1", "false start regen low", regen_low, 0);
        chk("R1", "false start flags", {dist_err, frame_err}, 0);
        run_frame(8'h81, 0, 0, 1'b1, 1'b1);
        chk("R1", "frame after false start", r_data, 8'h81);
    endtask

    task automatic t_frame_error();
        do_reset();
        mode = 2'b01; tol_sel = 2'b00;
        run_frame(8'h55, 0, 0, 1'b0, 1'b0);
        chk("R3", "low stop sets frame_err", frame_err, 1);
        chk("R3", "low stop no dist_err", dist_err, 0);
        chk("R6", "err_any from frame_err", err_any, 1);
        run_frame(8'h12, 0, 0, 1'b1, 1'b0);
        chk("R5", "frame_err held", frame_err, 1);
    endtask

    task automatic t_coincide();
        do_reset();
        mode = 2'b01; tol_sel = 2'b11;
        run_frame(8'h55, 3, 16, 1'b1, 1'b0);
        chk("R10", "flag edge at sample", r_err_at, 112);
        chk("R10", "strobe with flag", r_valid_at_err, 1);
        chk("R10", "byte with new level", r_data, 8'h55);
    endtask

    initial begin
        t_reset_state();
        t_clean_recv();
        t_tol_window();
        t_sticky();
        t_check_only();
        t_regen();
        t_false_start();
        t_frame_error();
        t_coincide();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule